// File: doc/BRIEF.md
# Pin Interrupt GPIO Controller

A 32-pin general-purpose I/O block on a small 32-bit register bus. Software sets the direction of each pin and the levels for pins that drive outputs. Input pads pass through a synchroniser. Each input pin watches for a level or an edge condition and sets a sticky status flag. Flags that are enabled are combined into interrupt request lines.

Each pin has a two-bit trigger code. A per-pin any-edge override can replace that code. The any-edge register exists only when a build parameter enables it. A second build parameter splits the interrupt output into a line for pins 0–15 and a line for pins 16–31. Reads are combinational from the address. A write takes effect at the next rising clock edge.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted, every register reads zero, `pad_oe` is zero and both `irq` lines are low.
- R2: `pad_oe` equals the direction register at offset 0x04, where 1 means output. `pad_out` carries the data register (0x00) on output pins and 0 on input pins.
- R3: A read of offset 0x00 returns data-register bits for output pins and synchronised pad levels for input pins.
- R4: A read of offset 0x08 returns synchronised pad levels with the bits of output pins forced to 0. Writes to 0x08 have no effect.
- R5: Pin n takes its trigger code from bits [2(n mod 16)+1 : 2(n mod 16)] of 0x0C for n < 16, and of 0x10 for n ≥ 16. Code 00 flags while the pad is low, 01 while it is high, 10 on a rising edge and 11 on a falling edge.
- R6: A pin whose bit is set in the any-edge register (0x1C) ignores its trigger code and flags on every change of its pad level.
- R7: Pins whose direction bit is 1 never set a status flag.
- R8: Status flags at 0x18 are sticky and cleared by writing 1. When a detection and a clear hit the same bit in the same cycle, the bit stays set, so an active level source reads set right after a clear.
- R9: Pending flags are status AND the enable register (0x14). With `SPLIT_IRQ`=0, `irq[0]` is the OR over all 32 pins and `irq[1]` is 0. With `SPLIT_IRQ`=1, `irq[0]` covers pins 15:0 and `irq[1]` covers pins 31:16.
- R10: With `ANY_EDGE_EN`=0, offset 0x1C reads zero, writes to it are ignored, and the trigger codes alone decide detection.
- R11: An access is mapped only if its two low address bits and all address bits above bit 4 are zero. Other addresses read zero and ignore writes.
- R12: A pad change applied before clock edge k is not yet visible in status after edge k+1. It sets the flag at edge k+2, with the default two synchroniser stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output levels, zero on input pins |
| pad_oe | output | 32 | Output enable per pin |
| irq | output | 2 | Interrupt request lines |

## Verification
A corrupted direction or data register shows on `pad_oe`/`pad_out` and in the 0x00/0x08 readback in the same cycle. A wrong trigger decode, a broken synchroniser stage or a lost override shows up as a status flag that is set or missing. That flag appears exactly two edges after the pad change and is read back through 0x18 or seen on `irq`. The bench samples status both one edge early and at the expected edge, so an extra or missing pipeline register is caught. Clear-versus-detect ordering is observed on the negative edge directly after the clearing write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NPINS = 32;
  localparam int unsigned HALF  = NPINS / 2;

  typedef enum logic [2:0] {
    REG_DATA     = 3'd0,
    REG_DIR      = 3'd1,
    REG_PAD      = 3'd2,
    REG_TRIG_LO  = 3'd3,
    REG_TRIG_HI  = 3'd4,
    REG_IRQ_EN   = 3'd5,
    REG_IRQ_FLAG = 3'd6,
    REG_ANY_EDGE = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_async,
  output logic [WIDTH-1:0] level_cur,
  output logic [WIDTH-1:0] level_prev
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pad_async;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign level_cur  = stage_q[STAGES-1];
  assign level_prev = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = NPINS
) (
  input  logic [PINS-1:0]   level_cur,
  input  logic [PINS-1:0]   level_prev,
  input  logic [PINS-1:0]   dir,
  input  logic [2*PINS-1:0] trig,
  input  logic [PINS-1:0]   any_edge,
  output logic [PINS-1:0]   hit
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    trig_e code;
    logic  rose;
    logic  fell;
    logic  cond;

    assign code = trig_e'(trig[2*i +: 2]);
    assign rose = level_cur[i] & ~level_prev[i];
    assign fell = ~level_cur[i] & level_prev[i];

    always_comb begin
      if (any_edge[i]) begin
        cond = rose | fell;
      end else begin
        unique case (code)
          TRIG_LOW:  cond = ~level_cur[i];
          TRIG_HIGH: cond = level_cur[i];
          TRIG_RISE: cond = rose;
          TRIG_FALL: cond = fell;
          default:   cond = 1'b0;
        endcase
      end
    end

    assign hit[i] = ~dir[i] & cond;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          ANY_EDGE_EN = 1'b1,
  parameter bit          SPLIT_IRQ   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [1:0]        irq
);
  localparam int unsigned WORD_LSB = 2;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned MAP_TOP  = WORD_LSB + SEL_W;

  logic [NPINS-1:0]   data_q, dir_q, irq_en_q, flag_q, any_edge_q;
  logic [2*NPINS-1:0] trig_q;
  logic [NPINS-1:0]   flag_d, clr_mask, hit, pend;
  logic [NPINS-1:0]   lvl_cur, lvl_prev;
  logic               in_map;
  reg_sel_e           sel;
  logic we_data, we_dir, we_tlo, we_thi, we_en, we_flag, we_any;

  // decode
  assign in_map = (bus_addr[ADDR_W-1:MAP_TOP] == '0) && (bus_addr[WORD_LSB-1:0] == '0);
  assign sel    = reg_sel_e'(bus_addr[WORD_LSB +: SEL_W]);

  always_comb begin
    we_data = 1'b0; we_dir = 1'b0; we_tlo = 1'b0; we_thi = 1'b0;
    we_en   = 1'b0; we_flag = 1'b0; we_any = 1'b0;
    if (bus_wr && in_map) begin
      unique case (sel)
        REG_DATA:     we_data = 1'b1;
        REG_DIR:      we_dir  = 1'b1;
        REG_TRIG_LO:  we_tlo  = 1'b1;
        REG_TRIG_HI:  we_thi  = 1'b1;
        REG_IRQ_EN:   we_en   = 1'b1;
        REG_IRQ_FLAG: we_flag = 1'b1;
        REG_ANY_EDGE: we_any  = 1'b1;
        default:      ;
      endcase
    end
  end

  gpio_pad_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_async  (pad_in),
    .level_cur  (lvl_cur),
    .level_prev (lvl_prev)
  );

  gpio_irq_detect #(.PINS(NPINS)) u_detect (
    .level_cur  (lvl_cur),
    .level_prev (lvl_prev),
    .dir        (dir_q),
    .trig       (trig_q),
    .any_edge   (any_edge_q),
    .hit        (hit)
  );

  // next state of the sticky flags: detection wins over clear
  always_comb begin
    clr_mask = we_flag ? bus_wdata : '0;
    flag_d   = (flag_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      trig_q   <= '0;
      irq_en_q <= '0;
      flag_q   <= '0;
    end else begin
      if (we_data) data_q <= bus_wdata;
      if (we_dir)  dir_q  <= bus_wdata;
      if (we_tlo)  trig_q[NPINS-1:0] <= bus_wdata;
      if (we_thi)  trig_q[2*NPINS-1:NPINS] <= bus_wdata;
      if (we_en)   irq_en_q <= bus_wdata;
      flag_q <= flag_d;
    end
  end

  if (ANY_EDGE_EN) begin : g_any_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      any_edge_q <= '0;
      else if (we_any) any_edge_q <= bus_wdata;
    end
  end else begin : g_no_any_edge
    assign any_edge_q = '0;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      unique case (sel)
        REG_DATA:     bus_rdata = (data_q & dir_q) | (lvl_cur & ~dir_q);
        REG_DIR:      bus_rdata = dir_q;
        REG_PAD:      bus_rdata = lvl_cur & ~dir_q;
        REG_TRIG_LO:  bus_rdata = trig_q[NPINS-1:0];
        REG_TRIG_HI:  bus_rdata = trig_q[2*NPINS-1:NPINS];
        REG_IRQ_EN:   bus_rdata = irq_en_q;
        REG_IRQ_FLAG: bus_rdata = flag_q;
        REG_ANY_EDGE: bus_rdata = any_edge_q;
        default:      bus_rdata = '0;
      endcase
    end
  end

  assign pad_out = data_q & dir_q;
  assign pad_oe  = dir_q;
  assign pend    = flag_q & irq_en_q;

  if (SPLIT_IRQ) begin : g_split
    assign irq = {|pend[NPINS-1:HALF], |pend[HALF-1:0]};
  end else begin : g_single
    assign irq = {1'b0, |pend};
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       pad_oe,
  input logic [1:0]        irq,
  input logic [31:0]       dir_q,
  input logic [31:0]       flag_q,
  input logic [31:0]       irq_en_q
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] A_PAD  = ADDR_W'(6'h08);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(6'h18);

  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> (pad_oe == $past(bus_wdata)));

  assert_pad_read_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_PAD) |-> ((bus_rdata & pad_oe) == '0));

  assert_inputs_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & $past(dir_q)) == '0));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_FLAG) |=> (($past(flag_q) & ~flag_q) == '0));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_q == '0) |-> (irq == 2'b00));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .dir_q     (dir_q),
  .flag_q    (flag_q),
  .irq_en_q  (irq_en_q)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] pad_in;
  logic [31:0] rdata_m, rdata_a, pout_m, pout_a, poe_m, poe_a;
  logic [1:0]  irq_m, irq_a;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_m), .pad_in(pad_in),
    .pad_out(pout_m), .pad_oe(poe_m), .irq(irq_m));

  gpio_irq_ctrl #(.ANY_EDGE_EN(1'b0), .SPLIT_IRQ(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .pad_in(pad_in),
    .pad_out(pout_a), .pad_oe(poe_a), .irq(irq_a));

  localparam int NV = 11;
  localparam logic [5:0]  V_WA  [NV] = '{6'h04, 6'h00, 6'h00, 6'h0C, 6'h10, 6'h14, 6'h1C, 6'h04, 6'h00, 6'h24, 6'h02};
  localparam logic [31:0] V_WD  [NV] = '{32'h0000_FFFF, 32'hCAFE_BEEF, 32'hCAFE_BEEF, 32'h8765_4321, 32'h0F0F_0F0F,
                                         32'h00FF_00FF, 32'h0000_0F00, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] V_PAD [NV] = '{32'h1234_5678, 32'h1234_5678, 32'h1234_5678, 32'h0, 32'h0,
                                         32'h0, 32'h0, 32'h1234_5678, 32'h1234_5678, 32'h0, 32'h0};
  localparam logic [5:0]  V_RA  [NV] = '{6'h00, 6'h00, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h1C, 6'h08, 6'h00, 6'h24, 6'h00};
  localparam logic [31:0] V_EXP [NV] = '{32'h1234_0000, 32'h1234_BEEF, 32'h1234_0000, 32'h8765_4321, 32'h0F0F_0F0F,
                                         32'h00FF_00FF, 32'h0000_0F00, 32'h0000_0000, 32'h0000_0001, 32'h0, 32'h0000_0001};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] m, output logic [31:0] al);
    bus_addr = a;
    #1;
    m = rdata_m; al = rdata_a;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pad_in = '0; bus_wr = 1'b0;
    clocks(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] m, al;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    clocks(2);

    // R1: all registers and outputs zero while in reset
    for (int r = 0; r < 8; r++) begin
      rd(6'(r * 4), m, al);
      check("R1 register reads zero in reset", m, 32'h0);
    end
    check("R1 pad_oe in reset", poe_m, 32'h0);
    check("R1 irq in reset", {30'h0, irq_m}, 32'h0);
    rst_n = 1'b1;

    // Table walk: R3, R4, R5 field readback, R6 register, R11 unmapped/misaligned
    for (int v = 0; v < NV; v++) begin
      pad_in = V_PAD[v];
      wr(V_WA[v], V_WD[v]);
      clocks(4);
      rd(V_RA[v], m, al);
      check($sformatf("R3/R4/R11 table row %0d", v), m, V_EXP[v]);
    end

    // R2: output drive
    do_reset();
    wr(6'h04, 32'h0000_00F0);
    wr(6'h00, 32'hFFFF_FFFF);
    check("R2 pad_oe", poe_m, 32'h0000_00F0);
    check("R2 pad_out", pout_m, 32'h0000_00F0);

    // R5/R8/R12/R9: level-high on pin 3
    do_reset();
    wr(6'h04, ~32'h8);
    wr(6'h0C, 32'h40);
    wr(6'h14, 32'h8);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, m, al);
    check("R5 level-high idle", m, 32'h0);
    pad_in = 32'h8;
    clocks(2);
    rd(6'h18, m, al);
    check("R12 not yet after two edges", m, 32'h0);
    clocks(1);
    rd(6'h18, m, al);
    check("R12 flag at third edge", m, 32'h8);
    check("R9 single line irq", {30'h0, irq_m}, 32'h1);
    wr(6'h18, 32'h8);
    rd(6'h18, m, al);
    check("R8 detection wins over clear", m, 32'h8);
    pad_in = 32'h0;
    clocks(3);
    wr(6'h18, 32'h8);
    rd(6'h18, m, al);
    check("R8 write-one clears", m, 32'h0);
    check("R9 irq drops", {30'h0, irq_m}, 32'h0);

    // R5: rising edge on pin 18
    do_reset();
    wr(6'h04, ~(32'h1 << 18));
    wr(6'h10, 32'h20);
    wr(6'h18, 32'hFFFF_FFFF);
    pad_in = 32'h1 << 18;
    clocks(3);
    rd(6'h18, m, al);
    check("R5 rising sets", m, 32'h1 << 18);
    wr(6'h18, 32'hFFFF_FFFF);
    pad_in = 32'h0;
    clocks(4);
    rd(6'h18, m, al);
    check("R5 rising ignores fall", m, 32'h0);

    // R5: falling edge on pin 18
    do_reset();
    pad_in = 32'h1 << 18;
    wr(6'h04, ~(32'h1 << 18));
    wr(6'h10, 32'h30);
    clocks(4);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, m, al);
    check("R5 falling idle high", m, 32'h0);
    pad_in = 32'h0;
    clocks(3);
    rd(6'h18, m, al);
    check("R5 falling sets", m, 32'h1 << 18);

    // R5/R8: level-low on pin 5 re-sets after clear
    do_reset();
    wr(6'h04, ~(32'h1 << 5));
    clocks(3);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, m, al);
    check("R8 level-low re-set", m, 32'h1 << 5);
    pad_in = 32'h1 << 5;
    clocks(3);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, m, al);
    check("R5 level-low quiet when high", m, 32'h0);

    // R6/R10: any-edge override on pin 9
    do_reset();
    wr(6'h04, ~(32'h1 << 9));
    wr(6'h1C, 32'h1 << 9);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, m, al);
    check("R6 override masks level code", m, 32'h0);
    check("R10 absent override leaves level code", al, 32'h1 << 9);
    rd(6'h1C, m, al);
    check("R6 override readback", m, 32'h1 << 9);
    check("R10 absent register reads zero", al, 32'h0);
    pad_in = 32'h1 << 9;
    clocks(3);
    rd(6'h18, m, al);
    check("R6 any-edge rise", m, 32'h1 << 9);
    wr(6'h18, 32'hFFFF_FFFF);
    pad_in = 32'h0;
    clocks(3);
    rd(6'h18, m, al);
    check("R6 any-edge fall", m, 32'h1 << 9);

    // R7: outputs never flag
    do_reset();
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h1C, 32'h1 << 9);
    wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h18, 32'hFFFF_FFFF);
    pad_in = 32'h1 << 9;
    clocks(3);
    pad_in = 32'h0;
    clocks(3);
    rd(6'h18, m, al);
    check("R7 no flag on output pins", m, 32'h0);
    check("R7 no irq on output pins", {30'h0, irq_m}, 32'h0);

    // R9: split lines on pin 20
    do_reset();
    wr(6'h04, ~(32'h1 << 20));
    wr(6'h10, 32'h100);
    wr(6'h14, 32'h1 << 20);
    wr(6'h18, 32'hFFFF_FFFF);
    pad_in = 32'h1 << 20;
    clocks(3);
    check("R9 single-line build upper pin", {30'h0, irq_m}, 32'h1);
    check("R9 split build upper pin", {30'h0, irq_a}, 32'h2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule